// File: doc/BRIEF.md
# Configurable Two-Cell Logic Slice

This block is a soft model of a small programmable logic slice. It holds two logic cells. Each cell has a 4-input look-up table, a selector in front of its storage element, and that storage element. A single serial chain loads every option bit. The table of each cell can serve as a fixed truth table, as a 16x1 memory that can be written, or as a 16-bit shift register with a selectable tap. One slice clock, one clock enable and one set/reset serve both cells. Configuration bits set the active edge or level of the clock, the polarity of the enable, the polarity and value of the set/reset, and whether the storage elements act as flip-flops or as transparent latches.

The model runs on one system clock `clk`. The slice clock `sclk` is sampled as data on every system edge. An active slice-clock edge is seen in the system cycle where the sampled level first differs from the previous sample and matches the configured active level. Register results and table writes appear at the ports one system cycle after that sample. Each cell drives a combinational output that is either its table read or its register, and it also drives its register value on its own port.

Top module: `lslice_top`

## Requirements
- R1: In logic mode (mode code 0, or spare code 3) a cell's table output is table bit `idx`, where `idx` is that cell's 4-bit input group read as an unsigned number with the highest-numbered bit as MSB. Cell 0 uses `lut_in[3:0]` and cell 1 uses `lut_in[7:4]`.
- R2: While `cfg_en` is high, every system edge shifts `cfg_din` into bit 0 of a 45-bit word, and all older bits move up by one. Read from MSB to LSB the word is: slice bits {sr_to_one, latch_mode, sr_act_high, ce_act_high, clk_falling}, then cell 0 {out_reg, d_direct, mode[1:0], table[15:0]}, then cell 1 in the same layout. Reset clears the whole word.
- R3: While `cfg_en` is high, neither register changes. In the first system cycle after `cfg_en` falls, both registers clear to 0.
- R4: When `out_reg` is 1, `y_out` of a cell equals its register. When `out_reg` is 0, `y_out` equals its table read. `q_out` always shows the register.
- R5: In flip-flop mode a register updates only on an active slice-clock edge. That is a rising edge when `clk_falling` is 0 and a falling edge when it is 1.
- R6: The enable counts as active when `sce` equals `ce_act_high`. While the enable is inactive, registers and tables keep their value.
- R7: The set/reset counts as active when `ssr` equals `sr_act_high`. At an update point it forces both registers to `sr_to_one`, and it overrides the enable.
- R8: The register input is the cell's `byp_in` bit when `d_direct` is 1 and its table read when `d_direct` is 0.
- R9: When `latch_mode` is 1, a register follows its input in every system cycle where the sampled `sclk` is at its active level (high if `clk_falling` is 0). At the other level it holds.
- R10: In RAM mode (code 1), an active edge with the enable active and the cell's `wr_en` high writes `wr_data` into table bit `idx`. Reads stay combinational and show the new bit one cycle later.
- R11: In shift mode (code 2), every active edge with the enable active shifts the table up by one and loads the cell's `wr_data` into bit 0. The output is tap `idx`.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every state element updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| sclk | input | 1 | Shared slice clock, sampled by `clk` |
| sce | input | 1 | Shared clock enable, polarity by configuration |
| ssr | input | 1 | Shared set/reset, polarity by configuration |
| lut_in | input | 8 | Table index inputs, 4 per cell |
| wr_data | input | 2 | Per-cell data for RAM writes and shift-in |
| wr_en | input | 2 | Per-cell RAM write enable |
| byp_in | input | 2 | Per-cell direct register input |
| y_out | output | 2 | Per-cell selected output (table read or register) |
| q_out | output | 2 | Per-cell register value |

## Verification
The bound checker checks the register rules on every cycle. Registers stay frozen during loading and clear after it. In flip-flop mode they do not move without an active edge. They do not move while the enable is inactive and the set/reset is idle. They are forced to the configured value when the set/reset is active at an update point. The bench's scenarios show the data behaviour: truth-table lookup, the table write and shift paths, the direct-input selection, and latch transparency. They also show the serial bit layout, which is only visible through the outputs once a full word has been loaded.

// File: rtl/lslice_pkg.sv
package lslice_pkg;

    localparam int LUT_K = 4;
    localparam int LUT_N = 1 << LUT_K;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_SPARE = 2'd3
    } lut_mode_e;

    // per-cell option word, MSB first as it sits in the chain
    typedef struct packed {
        logic             out_reg;
        logic             d_direct;
        lut_mode_e        mode;
        logic [LUT_N-1:0] table_bits;
    } cell_cfg_t;

    localparam int CELL_CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic sr_to_one;
        logic latch_mode;
        logic sr_act_high;
        logic ce_act_high;
        logic clk_falling;
    } slice_cfg_t;

    localparam int SLICE_CFG_W = $bits(slice_cfg_t);

    // shared control decoded once per slice
    typedef struct packed {
        logic cfg_busy;
        logic cfg_done;
        logic act_edge;
        logic gate_open;
        logic ce_on;
        logic sr_on;
        logic sr_val;
        logic latch_mode;
    } slice_ev_t;

endpackage

// File: rtl/lslice_ctrl.sv
module lslice_ctrl
    import lslice_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en,
    input  logic      cfg_si,
    input  logic      sclk,
    input  logic      sce,
    input  logic      ssr,
    output slice_ev_t ev
);

    typedef struct packed {
        slice_cfg_t cfg;
        logic       sclk_prev;
        logic       cfg_en_prev;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic [SLICE_CFG_W-1:0] cfg_bits;
    logic level_act;

    assign cfg_bits = st_q.cfg;

    always_comb begin
        st_d             = st_q;
        st_d.sclk_prev   = sclk;
        st_d.cfg_en_prev = cfg_en;
        if (cfg_en) begin
            st_d.cfg = slice_cfg_t'({cfg_bits[SLICE_CFG_W-2:0], cfg_si});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        level_act     = sclk ^ st_q.cfg.clk_falling;
        ev.cfg_busy   = cfg_en;
        ev.cfg_done   = !cfg_en && st_q.cfg_en_prev;
        ev.act_edge   = level_act && (sclk != st_q.sclk_prev);
        ev.gate_open  = level_act;
        ev.ce_on      = (sce == st_q.cfg.ce_act_high);
        ev.sr_on      = (ssr == st_q.cfg.sr_act_high);
        ev.sr_val     = st_q.cfg.sr_to_one;
        ev.latch_mode = st_q.cfg.latch_mode;
    end

endmodule

// File: rtl/lslice_cell.sv
module lslice_cell
    import lslice_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  slice_ev_t        ev,
    input  logic             cfg_si,
    output logic             cfg_so,
    input  logic [LUT_K-1:0] sel,
    input  logic             din,
    input  logic             we,
    input  logic             byp,
    output logic             y_o,
    output logic             q_o
);

    typedef struct packed {
        cell_cfg_t cfg;
        logic      q;
    } cell_st_t;

    cell_st_t st_q, st_d;
    logic [CELL_CFG_W-1:0] cfg_bits;
    logic lut_o;
    logic d_sel;
    logic upd;

    assign cfg_bits = st_q.cfg;
    assign cfg_so   = cfg_bits[CELL_CFG_W-1];
    assign lut_o    = st_q.cfg.table_bits[sel];
    assign d_sel    = st_q.cfg.d_direct ? byp : lut_o;
    assign upd      = ev.latch_mode ? ev.gate_open : ev.act_edge;

    always_comb begin
        st_d = st_q;
        if (ev.cfg_busy) begin
            st_d.cfg = cell_cfg_t'({cfg_bits[CELL_CFG_W-2:0], cfg_si});
        end else if (ev.cfg_done) begin
            st_d.q = 1'b0;
        end else begin
            if (ev.act_edge && ev.ce_on) begin
                case (st_q.cfg.mode)
                    MODE_RAM: begin
                        if (we) begin
                            st_d.cfg.table_bits[sel] = din;
                        end
                    end
                    MODE_SHIFT: begin
                        st_d.cfg.table_bits = {st_q.cfg.table_bits[LUT_N-2:0], din};
                    end
                    default: begin
                    end
                endcase
            end
            if (upd) begin
                if (ev.sr_on) begin
                    st_d.q = ev.sr_val;
                end else if (ev.ce_on) begin
                    st_d.q = d_sel;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;
    assign y_o = st_q.cfg.out_reg ? st_q.q : lut_o;

endmodule

// File: rtl/lslice_top.sv
module lslice_top
    import lslice_pkg::*;
#(
    parameter int NCELL = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic                   cfg_din,
    input  logic                   sclk,
    input  logic                   sce,
    input  logic                   ssr,
    input  logic [NCELL*LUT_K-1:0] lut_in,
    input  logic [NCELL-1:0]       wr_data,
    input  logic [NCELL-1:0]       wr_en,
    input  logic [NCELL-1:0]       byp_in,
    output logic [NCELL-1:0]       y_out,
    output logic [NCELL-1:0]       q_out
);

    slice_ev_t      ev;
    logic [NCELL:0] chain;

    // serial path: cfg_din -> cell NCELL-1 -> ... -> cell 0 -> shared control
    assign chain[NCELL] = cfg_din;

    lslice_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_en (cfg_en),
        .cfg_si (chain[0]),
        .sclk   (sclk),
        .sce    (sce),
        .ssr    (ssr),
        .ev     (ev)
    );

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        lslice_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (ev),
            .cfg_si (chain[k+1]),
            .cfg_so (chain[k]),
            .sel    (lut_in[k*LUT_K +: LUT_K]),
            .din    (wr_data[k]),
            .we     (wr_en[k]),
            .byp    (byp_in[k]),
            .y_o    (y_out[k]),
            .q_o    (q_out[k])
        );
    end

endmodule

// File: rtl/lslice_chk.sv
module lslice_chk
    import lslice_pkg::*;
#(
    parameter int NCELL = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [NCELL-1:0] q_out,
    input slice_ev_t        ev
);

    a_r3_cfg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(q_out));

    a_r3_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ev.cfg_done |=> (q_out == '0));

    a_r5_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev.cfg_busy && !ev.cfg_done && !ev.latch_mode && !ev.act_edge)
        |=> $stable(q_out));

    a_r6_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev.cfg_busy && !ev.cfg_done && !ev.sr_on && !ev.ce_on)
        |=> $stable(q_out));

    a_r7_sr_force: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev.cfg_busy && !ev.cfg_done && ev.sr_on &&
         (ev.latch_mode ? ev.gate_open : ev.act_edge))
        |=> (q_out == {NCELL{$past(ev.sr_val)}}));

endmodule

bind lslice_top lslice_chk #(.NCELL(NCELL)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .q_out  (q_out),
    .ev     (ev)
);

// File: tb/test_lslice_top.sv
module test_lslice_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_din = 1'b0;
    logic       sclk = 1'b0, sce = 1'b0, ssr = 1'b0;
    logic [7:0] lut_in = '0;
    logic [1:0] wr_data = '0, wr_en = '0, byp_in = '0;
    logic [1:0] y_out, q_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lslice_top i_lslice_top (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .sclk(sclk), .sce(sce), .ssr(ssr), .lut_in(lut_in),
        .wr_data(wr_data), .wr_en(wr_en), .byp_in(byp_in),
        .y_out(y_out), .q_out(q_out)
    );

    // {idx1, idx0, exp_y1, exp_y0}; cell0 = (i0&i1)|!i2, cell1 = parity
    localparam logic [9:0] VEC [8] = '{
        10'b0000_0000_0_1, 10'b0001_0100_1_0, 10'b0011_0111_0_1,
        10'b0111_1101_1_0, 10'b1111_1011_0_1, 10'b1000_1110_1_0,
        10'b1010_1111_0_1, 10'b1011_0101_1_0
    };
    localparam logic [15:0] T_F   = 16'h8F8F;
    localparam logic [15:0] T_PAR = 16'h6996;
    // slice word {sr_to_one, latch, sr_hi, ce_hi, clk_fall}
    localparam logic [4:0] S_STD = 5'b00110;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] cw(input logic oreg, input logic dd,
                                       input logic [1:0] md, input logic [15:0] t);
        return {oreg, dd, md, t};
    endfunction

    task automatic load_cfg(input logic [4:0] sc, input logic [19:0] c0, input logic [19:0] c1);
        logic [44:0] w;
        w = {sc, c0, c1};
        cfg_en = 1'b1;
        for (int i = 44; i >= 0; i--) begin
            cfg_din = w[i];
            step();
        end
        cfg_en = 1'b0;
        cfg_din = 1'b0;
        step();
    endtask

    task automatic pulse(input logic act_lvl);
        sclk = act_lvl;
        step();
        sclk = ~act_lvl;
        step();
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        check("R12 reset y", y_out, 2'b00);
        check("R12 reset q", q_out, 2'b00);

        // R1 R2 R4: table lookup on the combinational output
        load_cfg(S_STD, cw(0, 0, 2'd0, T_F), cw(0, 0, 2'd0, T_PAR));
        for (int i = 0; i < 8; i++) begin
            lut_in = VEC[i][9:2];
            #1;
            check($sformatf("R1 R2 vector %0d", i), y_out, VEC[i][1:0]);
        end
        check("R3 q clear after load", q_out, 2'b00);

        // R5 R4: rising-edge flip-flop
        load_cfg(S_STD, cw(1, 0, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR));
        sce = 1'b1; ssr = 1'b0;
        lut_in = {4'b0001, 4'b0000};
        step();
        check("R5 no edge yet", q_out, 2'b00);
        pulse(1'b1);
        check("R5 rising capture", q_out, 2'b11);
        check("R4 y shows register", y_out, 2'b11);
        lut_in = {4'b0000, 4'b0100};
        step();
        check("R5 hold without edge", q_out, 2'b11);
        pulse(1'b1);
        check("R5 rising capture zero", q_out, 2'b00);

        // R5: falling edge
        load_cfg(5'b00111, cw(1, 0, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR));
        lut_in = {4'b0001, 4'b0000};
        sclk = 1'b1;
        step();
        check("R5 rising ignored in falling mode", q_out, 2'b00);
        sclk = 1'b0;
        step();
        check("R5 falling capture", q_out, 2'b11);

        // R6: active-low enable
        load_cfg(5'b00100, cw(1, 0, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR));
        sce = 1'b1;
        pulse(1'b1);
        check("R6 inactive enable holds", q_out, 2'b00);
        sce = 1'b0;
        pulse(1'b1);
        check("R6 active-low enable captures", q_out, 2'b11);

        // R7: active-low set, overrides enable
        load_cfg(5'b10010, cw(1, 0, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR));
        lut_in = {4'b0000, 4'b0100};
        ssr = 1'b1; sce = 1'b1;
        pulse(1'b1);
        check("R7 set idle", q_out, 2'b00);
        ssr = 1'b0; sce = 1'b0;
        pulse(1'b1);
        check("R7 set beats enable", q_out, 2'b11);
        ssr = 1'b1; sce = 1'b1;
        pulse(1'b1);
        check("R7 released", q_out, 2'b00);

        // R8: direct input on cell 0 only
        ssr = 1'b0;
        load_cfg(S_STD, cw(1, 1, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR));
        lut_in = {4'b0001, 4'b0100};
        byp_in = 2'b01;
        pulse(1'b1);
        check("R8 direct and table", q_out, 2'b11);
        lut_in = {4'b0000, 4'b0000};
        byp_in = 2'b10;
        pulse(1'b1);
        check("R8 sources kept apart", q_out, 2'b00);

        // R9: latch mode
        load_cfg(5'b01110, cw(1, 1, 2'd0, 16'h0), cw(1, 1, 2'd0, 16'h0));
        byp_in = 2'b11;
        step();
        check("R9 gate closed", q_out, 2'b00);
        sclk = 1'b1;
        step();
        check("R9 gate open", q_out, 2'b11);
        byp_in = 2'b01;
        step();
        check("R9 transparent", q_out, 2'b01);
        sclk = 1'b0;
        step();
        byp_in = 2'b10;
        step();
        check("R9 closed holds", q_out, 2'b01);
        byp_in = 2'b00;

        // R10: RAM mode on cell 0
        load_cfg(S_STD, cw(0, 0, 2'd1, 16'h0), cw(0, 0, 2'd0, T_PAR));
        sce = 1'b1;
        lut_in = {4'b0000, 4'd5};
        #1;
        check("R10 empty entry", {1'b0, y_out[0]}, 2'b00);
        wr_data = 2'b01; wr_en = 2'b01;
        pulse(1'b1);
        check("R10 written entry", {1'b0, y_out[0]}, 2'b01);
        lut_in = {4'b0000, 4'd6};
        #1;
        check("R10 neighbour untouched", {1'b0, y_out[0]}, 2'b00);
        wr_data = 2'b00; wr_en = 2'b00;
        lut_in = {4'b0000, 4'd5};
        pulse(1'b1);
        check("R10 no write without enable", {1'b0, y_out[0]}, 2'b01);
        wr_data = 2'b01; wr_en = 2'b01; sce = 1'b0;
        lut_in = {4'b0000, 4'd9};
        pulse(1'b1);
        check("R10 R6 no write with clock enable off", {1'b0, y_out[0]}, 2'b00);
        wr_data = 2'b00; wr_en = 2'b00; sce = 1'b1;

        // R11: shift mode on cell 1, bits 1,1,0,1
        load_cfg(S_STD, cw(0, 0, 2'd0, T_F), cw(0, 0, 2'd2, 16'h0));
        wr_data = 2'b10; pulse(1'b1);
        wr_data = 2'b10; pulse(1'b1);
        wr_data = 2'b00; pulse(1'b1);
        wr_data = 2'b10; pulse(1'b1);
        wr_data = 2'b00;
        for (int t = 0; t < 5; t++) begin
            logic [4:0] taps;
            taps = 5'b01101;
            lut_in = {t[3:0], 4'b0000};
            #1;
            check($sformatf("R11 tap %0d", t), {1'b0, y_out[1]}, {1'b0, taps[t]});
        end

        // R3: frozen during loading, cleared afterwards
        load_cfg(S_STD, cw(1, 0, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR));
        lut_in = {4'b0001, 4'b0000};
        pulse(1'b1);
        check("R3 preset", q_out, 2'b11);
        lut_in = {4'b0000, 4'b0100};
        begin
            logic [44:0] w;
            w = {S_STD, cw(1, 0, 2'd0, T_F), cw(1, 0, 2'd0, T_PAR)};
            cfg_en = 1'b1;
            for (int i = 0; i < 45; i++) begin
                cfg_din = w[44-i];
                sclk = i[0];
                step();
                if (i == 20) check("R3 frozen while loading", q_out, 2'b11);
            end
            sclk = 1'b0;
            cfg_en = 1'b0;
            step();
            check("R3 cleared after loading", q_out, 2'b00);
            check("R4 y follows cleared register", y_out, 2'b00);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule